// File: doc/BRIEF.md
# Dual-Mode Bus Arbitration Unit

This block decides bus ownership for a host bridge and the three other masters that share its processor bus: two processors and one external agent, such as a cache or a second bridge. One group of six pins carries the arbitration traffic. What each pin means, and which way it points, depends on a mode strap. The block captures that strap while reset is held, and the captured value stays fixed until the next reset.

The block has two modes. In internal mode it reads active-low requests from the three other masters and the bridge's own active-high request. It then issues a single grant, chosen round-robin, and holds that grant until the owner withdraws its request. In external mode it forwards the bridge's request to an outside arbiter and returns that arbiter's grant to the bridge. It also watches all grant lines. In both modes a two-bit owner-ID register follows the current master, and in external mode a sticky flag records any cycle in which more than one grant was seen.

Each bidirectional pin is split into separate in, out and output-enable signals, so the block needs no tristate primitives.

Top module: `dual_mode_arbiter`

## Requirements
- R1: `mode_strap_i` is captured on every clock edge while `rst` is high, so the value present at the last reset edge is the one kept. It then holds until the next reset. `mode_internal_o` reports it: 1 means internal mode and 0 means external mode.
- R2: While `rst` is high, all four `pin_oe_o` bits are low. From the first edge after reset is released, `pin_oe_o` is 4'b0111 in internal mode and 4'b1000 in external mode.
- R3: In internal mode, requests arrive active low on `pin_in_i[3]` (processor 0), `pin_in_i[4]` (processor 1) and `pin_in_i[5]` (external master), and active high on `bridge_req_i`. A grant appears one edge after its request, active low on `pin_out_o[0]`, `pin_out_o[1]` and `pin_out_o[2]` for those same three masters, and active high on `bridge_gnt_o`.
- R4: In internal mode, at most one grant is active at any time.
- R5: A grant stays in place while its owner keeps requesting. One edge after the owner withdraws, the grant passes to the next requester, or no grant is given if none is waiting.
- R6: A new grant goes to the first active requester after the most recently granted master, in the cyclic order bridge, processor 0, processor 1, external master. After reset the search begins at the bridge.
- R7: The owner-ID encodings are bridge 2'b00, processor 0 2'b01, processor 1 2'b10 and external master 2'b11. In internal mode, `master_id_o` takes the grant holder's code one edge after the grant appears, and keeps its value while no grant is active.
- R8: In external mode, `pin_out_o[3]` equals the inverse of `bridge_req_i` one edge later, `bridge_gnt_o` equals the inverse of `pin_in_i[4]` one edge later, and `pin_out_o[2:0]` are held high.
- R9: In external mode, the observed grants are `pin_in_i[4]` (bridge), `pin_in_i[0]` (processor 0), `pin_in_i[1]` (processor 1) and `pin_in_i[2]` (external master), all active low. When exactly one of them is active, `master_id_o` takes its code one edge later. When none is active, the ID holds.
- R10: In external mode, two or more active observed grants leave the ID unchanged and set `multi_grant_err_o` one edge later. The flag stays set until reset. `pin_in_i[5]` has no effect in this mode.
- R11: Reset clears `master_id_o` to 2'b00 and `multi_grant_err_o` to 0, drives `pin_out_o` to all ones and drives `bridge_gnt_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_strap_i | input | 1 | Mode strap, 1 selects internal arbitration |
| bridge_req_i | input | 1 | Bridge's own bus request, active high |
| bridge_gnt_o | output | 1 | Bridge's own bus grant, active high |
| pin_in_i | input | 6 | Input side of the six arbitration pins |
| pin_out_o | output | 4 | Output side of the four bidirectional pins |
| pin_oe_o | output | 4 | Output enables of the bidirectional pins |
| mode_internal_o | output | 1 | Captured mode, 1 is internal |
| master_id_o | output | 2 | Current bus master ID |
| multi_grant_err_o | output | 1 | Sticky flag for overlapping observed grants |

## Verification
Every pin result (grant, forwarded request, forwarded grant, output enable) is due one edge after the stimulus. The external-mode ID and error flag are also due one edge after the grant lines change. The internal-mode ID is due two edges after a request, because it is taken from the already registered grant. The bench drives its inputs 1 ns after a rising edge and samples 1 ns after the following edge. Its reference model advances once per edge from the pre-edge state, so each comparison lands in the cycle its result is due.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_M = 4;
  localparam int ID_W  = $clog2(NUM_M);
  localparam int PIN_W = 6;
  localparam int BIDIR_W = 4;

  typedef logic [NUM_M-1:0] mvec_t;
  typedef logic [ID_W-1:0]  mid_t;

  // index of the single set bit (lowest wins if several)
  function automatic mid_t vec_to_id(input mvec_t v);
    mid_t r;
    r = '0;
    for (int i = NUM_M - 1; i >= 0; i--) begin
      if (v[i]) r = mid_t'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/arb_strap_latch.sv
module arb_strap_latch #(
  parameter int OE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strap_i,
  output logic            internal_o,
  output logic [OE_W-1:0] oe_o
);
  localparam logic [OE_W-1:0] OE_INT = {1'b0, {(OE_W-1){1'b1}}};
  localparam logic [OE_W-1:0] OE_EXT = {1'b1, {(OE_W-1){1'b0}}};

  logic            int_q;
  logic [OE_W-1:0] oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q <= strap_i;
      oe_q  <= '0;
    end else begin
      oe_q  <= int_q ? OE_INT : OE_EXT;
    end
  end

  assign internal_o = int_q;
  assign oe_o       = oe_q;
endmodule

// File: rtl/arb_rr_core.sv
module arb_rr_core #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     gnt_q;
  logic [IDX_W-1:0] last_q;
  logic [N-1:0]     pick;
  logic [IDX_W-1:0] pick_idx;
  logic [IDX_W-1:0] idx;
  logic             found;
  logic             hold;

  assign hold = |(gnt_q & req_i);

  always_comb begin
    pick     = '0;
    pick_idx = last_q;
    found    = 1'b0;
    idx      = '0;
    for (int k = 1; k <= N; k++) begin
      idx = IDX_W'((int'(last_q) + k) % N);
      if (!found && req_i[idx]) begin
        pick[idx] = 1'b1;
        pick_idx  = idx;
        found     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      gnt_q  <= '0;
      last_q <= IDX_W'(N - 1);
    end else if (!hold) begin
      gnt_q <= pick;
      if (found) last_q <= pick_idx;
    end
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/arb_id_track.sv
module arb_id_track
  import arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  internal_i,
  input  mvec_t own_gnt_i,
  input  mvec_t obs_gnt_i,
  output mid_t  id_o,
  output logic  err_o
);
  mvec_t sel;
  int    cnt;
  mid_t  id_q;
  logic  err_q;

  assign sel = internal_i ? own_gnt_i : obs_gnt_i;
  assign cnt = $countones(sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (cnt == 1) id_q <= vec_to_id(sel);
      if (!internal_i && cnt > 1) err_q <= 1'b1;
    end
  end

  assign id_o  = id_q;
  assign err_o = err_q;
endmodule

// File: rtl/dual_mode_arbiter.sv
module dual_mode_arbiter
  import arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_strap_i,
  input  logic               bridge_req_i,
  output logic               bridge_gnt_o,
  input  logic [PIN_W-1:0]   pin_in_i,
  output logic [BIDIR_W-1:0] pin_out_o,
  output logic [BIDIR_W-1:0] pin_oe_o,
  output logic               mode_internal_o,
  output logic [ID_W-1:0]    master_id_o,
  output logic               multi_grant_err_o
);
  logic  internal;
  mvec_t req_vec;
  mvec_t own_gnt;
  mvec_t obs_gnt;
  logic  ext_req_q;
  logic  ext_gnt_q;

  // master order: 0 bridge, 1 cpu0, 2 cpu1, 3 external agent
  assign req_vec = {~pin_in_i[5], ~pin_in_i[4], ~pin_in_i[3], bridge_req_i};
  assign obs_gnt = {~pin_in_i[2], ~pin_in_i[1], ~pin_in_i[0], ~pin_in_i[4]};

  arb_strap_latch #(.OE_W(BIDIR_W)) u_strap (
    .clk        (clk),
    .rst        (rst),
    .strap_i    (mode_strap_i),
    .internal_o (internal),
    .oe_o       (pin_oe_o)
  );

  arb_rr_core #(.N(NUM_M)) u_rr (
    .clk   (clk),
    .rst   (rst),
    .en_i  (internal),
    .req_i (req_vec),
    .gnt_o (own_gnt)
  );

  arb_id_track u_id (
    .clk        (clk),
    .rst        (rst),
    .internal_i (internal),
    .own_gnt_i  (own_gnt),
    .obs_gnt_i  (obs_gnt),
    .id_o       (master_id_o),
    .err_o      (multi_grant_err_o)
  );

  always_ff @(posedge clk) begin
    if (rst || internal) begin
      ext_req_q <= 1'b0;
      ext_gnt_q <= 1'b0;
    end else begin
      ext_req_q <= bridge_req_i;
      ext_gnt_q <= ~pin_in_i[4];
    end
  end

  assign pin_out_o       = internal ? {1'b1, ~own_gnt[3:1]} : {~ext_req_q, 3'b111};
  assign bridge_gnt_o    = internal ? own_gnt[0] : ext_gnt_q;
  assign mode_internal_o = internal;
endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic       clk,
  input logic       rst,
  input logic       mode_strap_i,
  input logic       bridge_req_i,
  input logic       bridge_gnt_o,
  input logic [5:0] pin_in_i,
  input logic [3:0] pin_out_o,
  input logic [3:0] pin_oe_o,
  input logic       mode_internal_o,
  input logic [1:0] master_id_o,
  input logic       multi_grant_err_o
);
  a_r1_mode_held: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_internal_o));

  a_r2_oe_by_mode: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pin_oe_o == (mode_internal_o ? 4'b0111 : 4'b1000));

  a_r4_single_grant: assert property (@(posedge clk) disable iff (rst)
    mode_internal_o |-> $onehot0({bridge_gnt_o, ~pin_out_o[2:0]}));

  a_r5_hold_grant: assert property (@(posedge clk) disable iff (rst)
    (mode_internal_o && bridge_gnt_o && bridge_req_i) |=> bridge_gnt_o);

  a_r8_req_forward: assert property (@(posedge clk) disable iff (rst)
    (!mode_internal_o && !$past(rst)) |-> pin_out_o[3] == !$past(bridge_req_i));

  a_r10_err_set: assert property (@(posedge clk) disable iff (rst)
    (!mode_internal_o &&
     $countones({~pin_in_i[4], ~pin_in_i[2:0]}) > 1) |=> multi_grant_err_o);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    multi_grant_err_o |=> multi_grant_err_o);

  logic unused_ok;
  assign unused_ok = ^{mode_strap_i, master_id_o, pin_in_i[5:3]};
endmodule

bind dual_mode_arbiter arb_checker i_chk (.*);

// File: tb/test_dual_mode_arbiter.sv
module test_dual_mode_arbiter;
  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst;
  logic       mode_strap_i;
  logic       bridge_req_i;
  logic       bridge_gnt_o;
  logic [5:0] pin_in_i;
  logic [3:0] pin_out_o;
  logic [3:0] pin_oe_o;
  logic       mode_internal_o;
  logic [1:0] master_id_o;
  logic       multi_grant_err_o;

  int checks = 0;
  int errors = 0;

  int exp_g;
  int exp_last;
  int exp_id;
  int exp_err;

  always #(CLK_P / 2) clk = ~clk;

  dual_mode_arbiter i_dual_mode_arbiter (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edge_wait();
    @(posedge clk);
    #1ns;
  endtask

  task automatic do_reset(input logic strap);
    rst = 1'b1;
    mode_strap_i = strap;
    bridge_req_i = 1'b0;
    pin_in_i = 6'b111111;
    edge_wait();
    edge_wait();
    chk("R2 oe in reset", pin_oe_o, 0);
    chk("R11 id in reset", master_id_o, 0);
    chk("R11 err in reset", multi_grant_err_o, 0);
    chk("R11 pins in reset", pin_out_o, 15);
    chk("R11 bridge gnt in reset", bridge_gnt_o, 0);
    rst = 1'b0;
    mode_strap_i = ~strap;   // later strap changes must not matter (R1)
    exp_g = -1; exp_last = 3; exp_id = 0; exp_err = 0;
  endtask

  // internal mode step: req bits 0 bridge, 1 cpu0, 2 cpu1, 3 external
  task automatic step_int(input logic [3:0] req);
    int ng;
    int nid;
    bridge_req_i = req[0];
    pin_in_i = {~req[3], ~req[2], ~req[1], 3'b111};
    nid = (exp_g >= 0) ? exp_g : exp_id;
    ng = -1;
    if (exp_g >= 0 && req[exp_g]) ng = exp_g;
    else begin
      for (int k = 1; k <= 4; k++) begin
        if (ng < 0 && req[(exp_last + k) % 4]) ng = (exp_last + k) % 4;
      end
    end
    if (ng >= 0) exp_last = ng;
    exp_g = ng;
    exp_id = nid;
    edge_wait();
    chk("R3/R5/R6 bridge grant", bridge_gnt_o, (ng == 0));
    chk("R3/R5/R6 grant pins", pin_out_o[2:0],
        {(ng != 3), (ng != 2), (ng != 1)});
    chk("R7 internal id", master_id_o, exp_id);
    chk("R2 oe internal", pin_oe_o, 7);
    chk("R1 mode held internal", mode_internal_o, 1);
  endtask

  // external mode step: g bits 0 bridge, 1 cpu0, 2 cpu1, 3 external
  task automatic step_ext(input logic breq, input logic [3:0] g, input logic p5);
    int cnt;
    bridge_req_i = breq;
    pin_in_i = {p5, ~g[0], 1'b1, ~g[3], ~g[2], ~g[1]};
    cnt = $countones(g);
    if (cnt == 1) begin
      for (int i = 0; i < 4; i++) if (g[i]) exp_id = i;
    end else if (cnt > 1) exp_err = 1;
    edge_wait();
    chk("R8 request forwarded", pin_out_o[3], !breq);
    chk("R8 grant pins idle", pin_out_o[2:0], 7);
    chk("R8 bridge grant forwarded", bridge_gnt_o, g[0]);
    chk("R9 external id", master_id_o, exp_id);
    chk("R10 multi grant flag", multi_grant_err_o, exp_err);
    chk("R2 oe external", pin_oe_o, 8);
    chk("R1 mode held external", mode_internal_o, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hold_n;
    int idle_id;
    #1ns;
    // internal mode
    do_reset(1'b1);
    step_int(4'b0000);
    chk("R1 mode internal", mode_internal_o, 1);
    // R6: all request, then each owner drops in turn
    step_int(4'b1111);
    step_int(4'b1110);
    step_int(4'b1100);
    step_int(4'b1000);
    step_int(4'b0000);
    // R7: ID holds while idle
    idle_id = master_id_o;
    step_int(4'b0000);
    chk("R7 id held when idle", master_id_o, idle_id);
    // near-exhaustive pattern sweep
    for (int rep = 0; rep < 3; rep++) begin
      for (int p = 0; p < 16; p++) begin
        hold_n = 1 + (p % 3);
        for (int h = 0; h < hold_n; h++) step_int(4'((p * 5 + rep * 3) % 16));
      end
    end
    step_int(4'b0000);
    step_int(4'b0000);

    // external mode
    do_reset(1'b0);
    edge_wait();
    chk("R1 mode external", mode_internal_o, 0);
    chk("R2 oe external first", pin_oe_o, 8);
    for (int pass = 0; pass < 2; pass++) begin
      for (int g = 0; g < 16; g++) begin
        step_ext(logic'(g[1] ^ pass[0]), 4'(g), logic'(g[0]));
      end
    end
    // R10: pin 5 has no effect
    step_ext(1'b1, 4'b0100, 1'b0);
    step_ext(1'b1, 4'b0100, 1'b1);
    step_ext(1'b0, 4'b0000, 1'b0);

    // R11: reset clears the sticky flag
    do_reset(1'b1);
    edge_wait();
    chk("R11 err cleared", multi_grant_err_o, 0);
    chk("R1 mode back to internal", mode_internal_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule